// File: doc/BRIEF.md
# Interval Timer with Limit Reload and Reached Flag

This block is a bus-programmed interval timer for a system I/O controller. An up-counter advances by one unit each time the tick-enable input is high on a clock edge. The count is presented to software scaled so that one unit sits at bit 9 of the word, and bits 8:0 always read as zero. Software programs a limit in the same scaled form. In system mode the counter restarts at zero whenever it reaches the limit, and each such event sets a sticky reached flag and a level interrupt. Software acknowledges the event by reading the limit.

In user mode the same counter becomes a wide free-running count with no limit events. Software reads it as a high word and a low word, and may halt and resume it. Per-processor instances may switch between the two modes. Fixed instances stay in system mode. The register interface uses single-cycle read and write strobes with the register index taken from address bits 4:2. Read data is registered and returned one cycle after the strobe.

Top module: `interval_timer`

## Requirements
- R1: After reset the limit reads 0x7FFFFE00, the count is zero and advances on ticks, the block is in system mode, not halted, irq is low and rdata is zero.
- R2: Each tick advances the count by one unit at bit 9. A read of index 1 returns the reached flag in bit 31 and the count in bits 30:9, with bits 8:0 zero. Indexes 4 to 7 read as zero.
- R3: In system mode, a tick that brings the count to the limit or beyond it sets the count to zero and sets both the reached flag and irq. This repeats every limit period.
- R4: In system mode a read of index 0 returns the limit in bits 30:9 and clears the reached flag and irq. If a limit event occurs on the same edge, the event wins and irq stays high.
- R5: A write to index 0 loads the limit, zeroes the count and clears the reached flag and irq. It takes priority over a tick on the same edge.
- R6: A write to index 1 loads the limit and leaves the count unchanged. If the count is already at or past the new limit, the next tick wraps it to zero and raises irq.
- R7: A written limit keeps only bits 30:9. If those bits are all zero, the limit becomes 0x7FFFFE00.
- R8: A write to index 2 halts the count when bit 0 is 1 and resumes it when bit 0 is 0. The write takes effect only in user mode. Bit 0 of an index 2 read returns the halted state.
- R9: A write to index 3 selects user mode when bit 0 is 1 and system mode when bit 0 is 0. On per-processor instances it also zeroes the count, clears the flag, irq and the halted state. On fixed instances it is ignored. Bit 0 of an index 3 read returns the mode.
- R10: In user mode the count never sets the flag or irq. A read of index 1 returns count units 21:0 in bits 30:9. A read of index 0 returns units 52:22 in bits 30:0 and does not clear irq.
- R11: rdata changes only on the edge that samples rd_en. It reflects the state before that edge, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; bits 4:2 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
The counting function is driven with three kinds of limit: a short one that wraps on every tick, mid-range limits that are reached after a few ticks, and a limit that is lowered below the running count. The short limit shows whether a pending event survives an acknowledge on the same edge. The lowered limit shows whether the wrap uses a reaching comparison or a plain equality test. Limit writes with a zero field, and with only bits outside 30:9 set, separate the zero substitution from plain masking. User-mode runs with and without a halt check the free-running count. A narrow instance carries the count into the high word after a few ticks. A fixed instance shows that its mode writes are ignored.

// File: rtl/timer_pkg.sv
// Package: shared register indexes for the interval timer.
// Assumes a word-addressed map of eight slots; only the first four decode.
package timer_pkg;

    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_LIM_CLR  = 3'd0;  // limit, counter reset
    localparam logic [IDX_W-1:0] IDX_LIM_KEEP = 3'd1;  // limit, counter kept
    localparam logic [IDX_W-1:0] IDX_RUNCTL   = 3'd2;  // halt / resume
    localparam logic [IDX_W-1:0] IDX_MODE     = 3'd3;  // mode select

    // Control strobes from the decoder to the counter core.
    typedef struct packed {
        logic cnt_zero;   // zero counter and clear flag
        logic ack;        // acknowledge read in system mode
    } tmr_ctl_t;

endpackage

// File: rtl/timer_decode.sv
// Module: timer_decode
// Decodes write and read strobes, holds the limit, mode and halt registers.
// Assumes single-cycle strobes; the index is taken from the address bits above the byte lane.
module timer_decode
    import timer_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int TICK_SH = 9,
    parameter int PER_CPU = 1,
    parameter int UNIT_W  = CNT_W - TICK_SH,
    parameter int DATA_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [UNIT_W-1:0] limit_u,
    output logic              user_mode,
    output logic              halted,
    output tmr_ctl_t          ctl
);

    localparam logic [UNIT_W-1:0] LIM_MAX = {UNIT_W{1'b1}};

    logic              wr_clr, wr_keep, wr_run, wr_mode;
    logic              mode_take;
    logic [UNIT_W-1:0] lim_field;
    logic              unused_wbits;

    // Write strobe per register slot.
    always_comb begin
        wr_clr  = wr_en && (idx == IDX_LIM_CLR);
        wr_keep = wr_en && (idx == IDX_LIM_KEEP);
        wr_run  = wr_en && (idx == IDX_RUNCTL);
        wr_mode = wr_en && (idx == IDX_MODE);
    end

    // Masked limit field with zero replaced by the largest value.
    always_comb begin
        lim_field = wdata[CNT_W-1:TICK_SH];
        if (lim_field == '0)
            lim_field = LIM_MAX;
    end

    assign unused_wbits = ^{wdata[DATA_W-1], wdata[TICK_SH-1:1]};

    // Limit register, loaded from either limit slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_u <= LIM_MAX;
        else if (wr_clr || wr_keep)
            limit_u <= lim_field;
    end

    // Mode register exists only on per-processor instances.
    generate
        if (PER_CPU != 0) begin : g_mode
            // Mode bit follows wdata[0] on an accepted mode write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    user_mode <= 1'b0;
                else if (wr_mode)
                    user_mode <= wdata[0];
            end
            assign mode_take = wr_mode;
        end else begin : g_fixed
            assign user_mode = 1'b0;
            assign mode_take = 1'b0;
        end
    endgenerate

    // Halt state, writable only in user mode, cleared by a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (mode_take)
            halted <= 1'b0;
        else if (wr_run && user_mode)
            halted <= wdata[0];
    end

    // Strobes to the counter core.
    always_comb begin
        ctl.cnt_zero = wr_clr || mode_take;
        ctl.ack      = rd_en && (idx == IDX_LIM_CLR) && !user_mode;
    end

    assert_limit_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        limit_u != '0);

    assert_sys_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> !halted);

    assert_zero_subst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_LIM_CLR && wdata[CNT_W-1:TICK_SH] == '0) |=> limit_u == LIM_MAX);

endmodule

// File: rtl/timer_core.sv
// Module: timer_core
// Up-counter in tick units with limit wrap, sticky reached flag and acknowledge.
// Assumes the limit is never zero. In system mode the count stays below 2**UNIT_W.
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int TICK_SH = 9,
    parameter int UNIT_W  = CNT_W - TICK_SH,
    parameter int UCNT_W  = UNIT_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              user_mode,
    input  logic              halted,
    input  logic [UNIT_W-1:0] limit_u,
    input  tmr_ctl_t          ctl,
    output logic [UCNT_W-1:0] cnt_u,
    output logic              reached
);

    logic              step;
    logic [UNIT_W:0]   low_next;
    logic              hit;

    // Advance condition and limit comparison for the next count.
    always_comb begin
        step     = tick_en && !halted;
        low_next = {1'b0, cnt_u[UNIT_W-1:0]} + 1'b1;
        hit      = step && !user_mode && (low_next >= {1'b0, limit_u});
    end

    // Counter: write reset first, then wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_u <= '0;
        else if (ctl.cnt_zero)
            cnt_u <= '0;
        else if (hit)
            cnt_u <= '0;
        else if (step)
            cnt_u <= cnt_u + 1'b1;
    end

    // Reached flag: cleared by write, set by event, then acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reached <= 1'b0;
        else if (ctl.cnt_zero)
            reached <= 1'b0;
        else if (hit)
            reached <= 1'b1;
        else if (ctl.ack)
            reached <= 1'b0;
    end

    assert_zero_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.cnt_zero |=> (cnt_u == '0) && !reached);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ctl.cnt_zero) |=> $stable(cnt_u));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ack && !tick_en && !ctl.cnt_zero) |=> !reached);

    assert_user_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> !$rose(reached));

    assert_sys_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> (cnt_u[UCNT_W-1:UNIT_W] == '0));

endmodule

// File: rtl/timer_rdmux.sv
// Module: timer_rdmux
// Registered read-data selector for the timer registers.
// Assumes rd_en is a single-cycle strobe. Data reflects the state before the sampling edge.
module timer_rdmux
    import timer_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int TICK_SH = 9,
    parameter int UNIT_W  = CNT_W - TICK_SH,
    parameter int UCNT_W  = UNIT_W + CNT_W,
    parameter int DATA_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              user_mode,
    input  logic              halted,
    input  logic [UNIT_W-1:0] limit_u,
    input  logic [UCNT_W-1:0] cnt_u,
    input  logic              reached,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    // Word selection by index and mode.
    always_comb begin
        sel = '0;
        case (idx)
            IDX_LIM_CLR:
                if (user_mode)
                    sel = {1'b0, cnt_u[UCNT_W-1:UNIT_W]};
                else
                    sel = {1'b0, limit_u, {TICK_SH{1'b0}}};
            IDX_LIM_KEEP: sel = {reached, cnt_u[UNIT_W-1:0], {TICK_SH{1'b0}}};
            IDX_RUNCTL:   sel = {{(DATA_W-1){1'b0}}, halted};
            IDX_MODE:     sel = {{(DATA_W-1){1'b0}}, user_mode};
            default:      sel = '0;
        endcase
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_LIM_KEEP) |=> rdata[TICK_SH-1:0] == '0);

endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer (top)
// Bus-programmed interval timer: limit reload, reached flag, level irq, system/user modes.
// Assumes single-cycle rd_en/wr_en strobes and a clock-synchronous tick_en.
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int TICK_SH = 9,
    parameter int ADDR_W  = 5,
    parameter int PER_CPU = 1,
    parameter int DATA_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int UNIT_W  = CNT_W - TICK_SH;
    localparam int UCNT_W  = UNIT_W + CNT_W;
    localparam int IDX_LSB = 2;

    logic [IDX_W-1:0]  idx;
    logic [UNIT_W-1:0] limit_u;
    logic              user_mode;
    logic              halted;
    tmr_ctl_t          ctl;
    logic [UCNT_W-1:0] cnt_u;
    logic              reached;
    logic              unused_abits;

    assign idx          = addr[IDX_LSB +: IDX_W];
    assign unused_abits = ^addr[IDX_LSB-1:0];

    timer_decode #(
        .CNT_W(CNT_W), .TICK_SH(TICK_SH), .PER_CPU(PER_CPU),
        .UNIT_W(UNIT_W), .DATA_W(DATA_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
        .wdata(wdata), .limit_u(limit_u), .user_mode(user_mode),
        .halted(halted), .ctl(ctl)
    );

    timer_core #(
        .CNT_W(CNT_W), .TICK_SH(TICK_SH), .UNIT_W(UNIT_W), .UCNT_W(UCNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
        .halted(halted), .limit_u(limit_u), .ctl(ctl),
        .cnt_u(cnt_u), .reached(reached)
    );

    timer_rdmux #(
        .CNT_W(CNT_W), .TICK_SH(TICK_SH), .UNIT_W(UNIT_W),
        .UCNT_W(UCNT_W), .DATA_W(DATA_W)
    ) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .idx(idx),
        .user_mode(user_mode), .halted(halted), .limit_u(limit_u),
        .cnt_u(cnt_u), .reached(reached), .rdata(rdata)
    );

    assign irq = reached;

    assert_irq_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en));

endmodule

// File: tb/test_interval_timer.sv
// Bench for interval_timer: vector table walk, then directed corner tests.
module test_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic        irq;
    } vec_t;

    localparam int NVEC = 45;
    localparam vec_t VEC [NVEC] = '{
        '{OP_WR, 3'd0, 32'h0000_0A00, 32'h0, 1'b0},  // R5 limit 5 units
        '{OP_TK, 3'd0, 32'd3,         32'h0, 1'b0},  // R2
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0600, 1'b0}, // R2
        '{OP_TK, 3'd0, 32'd2,         32'h0, 1'b1},  // R3 wrap
        '{OP_RD, 3'd1, 32'h0,         32'h8000_0000, 1'b1}, // R3
        '{OP_RD, 3'd0, 32'h0,         32'h0000_0A00, 1'b0}, // R4 ack
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0000, 1'b0}, // R4
        '{OP_WR, 3'd1, 32'h0000_0401, 32'h0, 1'b0},  // R6 R7 limit 2
        '{OP_TK, 3'd0, 32'd1,         32'h0, 1'b0},
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0200, 1'b0}, // R6
        '{OP_TK, 3'd0, 32'd1,         32'h0, 1'b1},  // R3 repeat
        '{OP_RD, 3'd1, 32'h0,         32'h8000_0000, 1'b1},
        '{OP_WR, 3'd0, 32'h0000_0000, 32'h0, 1'b0},  // R7 zero
        '{OP_RD, 3'd0, 32'h0,         32'h7FFF_FE00, 1'b0}, // R7
        '{OP_WR, 3'd0, 32'h8000_01FF, 32'h0, 1'b0},  // R7 masked zero
        '{OP_RD, 3'd0, 32'h0,         32'h7FFF_FE00, 1'b0}, // R7
        '{OP_WR, 3'd0, 32'h0000_1400, 32'h0, 1'b0},  // limit 10
        '{OP_TK, 3'd0, 32'd4,         32'h0, 1'b0},
        '{OP_WR, 3'd1, 32'h0000_0600, 32'h0, 1'b0},  // R6 limit 3 below count
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0800, 1'b0}, // R6 count kept
        '{OP_TK, 3'd0, 32'd1,         32'h0, 1'b1},  // R6 past limit wraps
        '{OP_RD, 3'd1, 32'h0,         32'h8000_0000, 1'b1},
        '{OP_RD, 3'd0, 32'h0,         32'h0000_0600, 1'b0}, // R4
        '{OP_RD, 3'd2, 32'h0,         32'h0000_0000, 1'b0}, // R8
        '{OP_WR, 3'd2, 32'h0000_0001, 32'h0, 1'b0},  // R8 ignored in system
        '{OP_RD, 3'd2, 32'h0,         32'h0000_0000, 1'b0}, // R8
        '{OP_TK, 3'd0, 32'd1,         32'h0, 1'b0},
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0200, 1'b0}, // R8 still running
        '{OP_RD, 3'd3, 32'h0,         32'h0000_0000, 1'b0}, // R9
        '{OP_WR, 3'd3, 32'h0000_0001, 32'h0, 1'b0},  // R9 user mode
        '{OP_RD, 3'd3, 32'h0,         32'h0000_0001, 1'b0}, // R9
        '{OP_TK, 3'd0, 32'd3,         32'h0, 1'b0},
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0600, 1'b0}, // R9 R10 restarted
        '{OP_RD, 3'd0, 32'h0,         32'h0000_0000, 1'b0}, // R10 high word
        '{OP_WR, 3'd2, 32'h0000_0001, 32'h0, 1'b0},  // R8 halt
        '{OP_RD, 3'd2, 32'h0,         32'h0000_0001, 1'b0}, // R8
        '{OP_TK, 3'd0, 32'd2,         32'h0, 1'b0},
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0600, 1'b0}, // R8 held
        '{OP_WR, 3'd2, 32'h0000_0000, 32'h0, 1'b0},  // R8 resume
        '{OP_TK, 3'd0, 32'd1,         32'h0, 1'b0},  // R10 past limit, no flag
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0800, 1'b0}, // R10
        '{OP_RD, 3'd5, 32'h0,         32'h0000_0000, 1'b0}, // R2 unused slot
        '{OP_WR, 3'd3, 32'h0000_0000, 32'h0, 1'b0},  // R9 back to system
        '{OP_RD, 3'd1, 32'h0,         32'h0000_0000, 1'b0}, // R9 count zeroed
        '{OP_RD, 3'd3, 32'h0,         32'h0000_0000, 1'b0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, wr_en, rd_en;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata, rdata_fx;
    logic [12:0] rdata_nw;
    logic        irq, irq_fx, irq_nw;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    interval_timer #(.PER_CPU(0)) i_interval_timer_fixed (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_fx), .irq(irq_fx)
    );

    interval_timer #(.CNT_W(12)) i_interval_timer_narrow (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata[12:0]), .rdata(rdata_nw), .irq(irq_nw)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; addr = {idx, 2'b00}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] idx);
        rd_en = 1'b1; addr = {idx, 2'b00};
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rdata", rdata, 32'h0);
        check("R1 fixed irq", {31'b0, irq_fx}, 32'h0);
        do_rd(3'd0); check("R1 limit", rdata, 32'h7FFF_FE00);
        do_rd(3'd3); check("R1 mode", rdata, 32'h0);
        do_rd(3'd2); check("R1 halted", rdata, 32'h0);
        do_tick(2);
        do_rd(3'd1); check("R1 R2 running", rdata, 32'h0000_0400);

        // Vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v].op)
                OP_WR: do_wr(VEC[v].idx, VEC[v].data);
                OP_RD: begin
                    do_rd(VEC[v].idx);
                    check($sformatf("vec %0d rdata", v), rdata, VEC[v].exp);
                end
                default: do_tick(int'(VEC[v].data));
            endcase
            check($sformatf("vec %0d irq R3", v), {31'b0, irq}, {31'b0, VEC[v].irq});
        end

        // R4: acknowledge on the same edge as a new event; the event wins.
        do_wr(3'd0, 32'h0000_0200);
        do_tick(1);
        check("R3 irq limit 1", {31'b0, irq}, 32'h1);
        rd_en = 1'b1; tick_en = 1'b1; addr = 5'h00;
        @(negedge clk);
        rd_en = 1'b0; tick_en = 1'b0;
        check("R4 set wins irq", {31'b0, irq}, 32'h1);
        check("R4 set wins rdata", rdata, 32'h0000_0200);
        do_rd(3'd0);
        check("R4 ack clears", {31'b0, irq}, 32'h0);

        // R5: counter-reset write beats a tick on the same edge.
        do_wr(3'd0, 32'h0000_1400);
        do_tick(2);
        wr_en = 1'b1; tick_en = 1'b1; addr = 5'h00; wdata = 32'h0000_1400;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        do_rd(3'd1); check("R5 write wins", rdata, 32'h0);

        // R1: reset in the middle of an event.
        do_wr(3'd0, 32'h0000_0200);
        do_tick(1);
        check("R3 irq before reset", {31'b0, irq}, 32'h1);
        do_reset();
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        do_rd(3'd0); check("R1 limit after reset", rdata, 32'h7FFF_FE00);

        // R9: fixed instance ignores mode writes.
        do_wr(3'd3, 32'h1);
        do_rd(3'd3);
        check("R9 per-cpu mode", rdata, 32'h1);
        check("R9 fixed mode", rdata_fx, 32'h0);
        do_wr(3'd2, 32'h1);
        do_rd(3'd2);
        check("R8 fixed halt ignored", rdata_fx, 32'h0);
        check("R8 per-cpu halted", rdata, 32'h1);

        // R10: narrow instance carries into the high word.
        do_reset();
        do_rd(3'd0); check("R7 narrow reset limit", {19'b0, rdata_nw}, 32'h0000_0E00);
        do_wr(3'd3, 32'h1);
        do_tick(9);
        do_rd(3'd0);
        check("R10 narrow high", {19'b0, rdata_nw}, 32'h1);
        check("R10 wide high", rdata, 32'h0);
        do_rd(3'd1);
        check("R10 narrow low", {19'b0, rdata_nw}, 32'h0000_0200);
        check("R10 wide low", rdata, 32'h0000_1200);

        // R11: rdata holds without a read strobe.
        do_tick(3);
        check("R11 hold", rdata, 32'h0000_1200);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule